// File: doc/BRIEF.md
# Tail-Aligned PWM Generator with Boundary-Synchronised Width Update

This block produces a fixed-frequency pulse-width-modulated output from a free-running 16-bit tick counter that advances once per clock. Two compare times are kept against that counter. The period compare marks where each period begins, drives the output low, and moves forward by `period_i` ticks each time it matches. The width compare drives the output high. The high part of each period therefore sits at its tail: it starts `W` ticks before the next period begins, where `W` is the active width.

Software or a profile generator places a new width on `width_i` and pulses `upd_req_i`. The request only sets a pending flag. The new width is not sampled until the next period boundary. At that boundary the flag is cleared and the width compare is placed at the new period's start plus one period minus the new width. Between requests, the width compare advances by one period each time it matches. A running period is therefore never cut short or stretched by an update. `period_start_o` pulses for one cycle at every boundary. A width of zero gives a period that is low throughout. A width equal to or greater than the period gives a period that is high throughout.

Top module: `pwm_tail_gen`

## Requirements
- R1: While `rst_n` is low, `pwm_o` and `period_start_o` are 0. Both stay 0 from reset release until the first period boundary.
- R2: `period_start_o` is high for exactly one cycle at each boundary. Consecutive pulses are `period_i` cycles apart, with `period_i` read at each boundary to schedule the next one (`period_i` at least 2).
- R3: With an active width W where 0 < W < period, `pwm_o` is 0 in the first period−W cycles of a period, counting the cycle in which `period_start_o` is 1, and 1 in its last W cycles. Once high, it stays high until the next boundary.
- R4: An active width of 0 keeps `pwm_o` at 0 for the whole period.
- R5: An active width equal to or greater than `period_i` keeps `pwm_o` at 1 in every cycle of the period, including the `period_start_o` cycle.
- R6: A change on `width_i` that is not accompanied by an `upd_req_i` pulse has no effect on `pwm_o`.
- R7: An `upd_req_i` pulse sets a pending flag. At the next boundary, `width_i` is sampled and becomes the active width for the period that starts there and for every later period. The flag is then cleared. The active width does not change at any other time.
- R8: After reset, the active width is 0 until the first update is consumed. Until then, `pwm_o` stays low while boundaries keep pulsing.
- R9: All compare times wrap modulo 2^16. Period length and high time stay exact when the tick counter rolls over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| period_i | input | 16 | Period length in ticks |
| width_i | input | 16 | Requested high time in ticks, sampled at the boundary after a request |
| upd_req_i | input | 1 | One-cycle strobe that marks `width_i` for loading at the next boundary |
| pwm_o | output | 1 | PWM output, high in the tail of each period |
| period_start_o | output | 1 | One-cycle pulse in the first cycle of each period |

## Verification
Each period is measured between two `period_start_o` pulses. The measurement gives the period length, the number of high cycles and the index of the first high cycle. These three values separate a pulse placed at the tail from one at the head or one of the wrong length. Widths of 1, 50 and period−1 exercise the normal path. Widths of 0, exactly the period and above the period exercise the saturating cases. A return from full-high to a partial width shows that the pending update is consumed even when the width compare has drifted out of range. A change on `width_i` without a strobe must leave the next period unchanged. A combined change of period and width checks the scheduling arithmetic with a new period length. A run of several hundred periods across the counter rollover shows that the modular compares hold their timing.

// File: rtl/pwm_tail_pkg.sv
package pwm_tail_pkg;

  // Action applied to the output register at a clock edge
  typedef enum logic [1:0] {
    PA_HOLD = 2'd0,
    PA_LOW  = 2'd1,
    PA_HIGH = 2'd2
  } pwm_act_e;

  // Compare events raised by the scheduler in the current cycle
  typedef struct packed {
    logic bnd;     // tick counter equals the period compare time
    logic wmatch;  // tick counter equals the width compare time
    logic load;    // boundary with a pending width update
  } sched_evt_t;

endpackage

// File: rtl/pwm_tail_update.sv
module pwm_tail_update #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic          consume_i,
  input  logic [CW-1:0] width_i,
  output logic          pend_o,
  output logic [CW-1:0] act_w_o
);

  logic          pend_q, pend_d;
  logic [CW-1:0] act_w_q, act_w_d;
  logic          act_w_en;

  // A new request wins over consumption, so a strobe in the boundary
  // cycle re-arms the flag for the following boundary.
  always_comb begin
    pend_d = pend_q;
    if (req_i)          pend_d = 1'b1;
    else if (consume_i) pend_d = 1'b0;
    act_w_en = consume_i;
    act_w_d  = width_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      act_w_q <= '0;
    end else begin
      pend_q <= pend_d;
      if (act_w_en) act_w_q <= act_w_d;
    end
  end

  assign pend_o  = pend_q;
  assign act_w_o = act_w_q;

endmodule

// File: rtl/pwm_tail_sched.sv
module pwm_tail_sched
  import pwm_tail_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] period_i,
  input  logic [CW-1:0] width_i,
  input  logic          pend_i,
  output sched_evt_t    evt_o
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          run_q;
  logic [CW-1:0] pcmp_q, pcmp_d;
  logic [CW-1:0] wcmp_q, wcmp_d;
  logic          pcmp_en, wcmp_en;
  logic [CW-1:0] three_per;
  sched_evt_t    evt;

  assign three_per = period_i + {period_i[CW-2:0], 1'b0};

  // Compare detection against the free-running counter
  always_comb begin
    evt.bnd    = run_q && (cnt_q == pcmp_q);
    evt.wmatch = run_q && (cnt_q == wcmp_q);
    evt.load   = evt.bnd && pend_i;
  end

  // Next compare times; all sums wrap modulo 2^CW
  always_comb begin
    cnt_d   = cnt_q + 1'b1;
    pcmp_d  = pcmp_q;
    wcmp_d  = wcmp_q;
    pcmp_en = 1'b0;
    wcmp_en = 1'b0;
    if (!run_q) begin
      // Start-up: first boundary one period out, width compare three out
      pcmp_d  = cnt_q + period_i;
      wcmp_d  = cnt_q + three_per;
      pcmp_en = 1'b1;
      wcmp_en = 1'b1;
    end else begin
      if (evt.bnd) begin
        pcmp_d  = pcmp_q + period_i;
        pcmp_en = 1'b1;
      end
      if (evt.load) begin
        // New period starts at pcmp_q; high part begins W before its end
        wcmp_d  = pcmp_q + period_i - width_i;
        wcmp_en = 1'b1;
      end else if (evt.wmatch) begin
        wcmp_d  = wcmp_q + period_i;
        wcmp_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      pcmp_q <= '0;
      wcmp_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= 1'b1;
      if (pcmp_en) pcmp_q <= pcmp_d;
      if (wcmp_en) wcmp_q <= wcmp_d;
    end
  end

  assign evt_o = evt;

endmodule

// File: rtl/pwm_tail_out.sv
module pwm_tail_out
  import pwm_tail_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  sched_evt_t    evt_i,
  input  logic [CW-1:0] act_w_i,
  input  logic [CW-1:0] width_i,
  input  logic [CW-1:0] period_i,
  output logic          pwm_o,
  output logic          pstart_o
);

  logic [CW-1:0] eff_w;
  logic          full;
  pwm_act_e      act;
  logic          pwm_q, pwm_d;
  logic          pst_q, pst_d;

  // Width that governs the period opening at this boundary
  assign eff_w = evt_i.load ? width_i : act_w_i;
  assign full  = (eff_w >= period_i);

  // Boundary has priority over a coincident width match
  always_comb begin
    if (evt_i.bnd)                             act = full ? PA_HIGH : PA_LOW;
    else if (evt_i.wmatch && (act_w_i != '0))  act = PA_HIGH;
    else                                       act = PA_HOLD;
  end

  always_comb begin
    case (act)
      PA_LOW:  pwm_d = 1'b0;
      PA_HIGH: pwm_d = 1'b1;
      default: pwm_d = pwm_q;
    endcase
    pst_d = evt_i.bnd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_q <= 1'b0;
      pst_q <= 1'b0;
    end else begin
      pwm_q <= pwm_d;
      pst_q <= pst_d;
    end
  end

  assign pwm_o    = pwm_q;
  assign pstart_o = pst_q;

endmodule

// File: rtl/pwm_tail_gen.sv
module pwm_tail_gen
  import pwm_tail_pkg::*;
#(
  parameter int unsigned CW          = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] period_i,
  input  logic [CW-1:0] width_i,
  input  logic          upd_req_i,
  output logic          pwm_o,
  output logic          period_start_o
);

  localparam int unsigned SYNC_MSB = SYNC_STAGES - 1;

  logic [SYNC_MSB:0] rst_sync_q;
  logic              rst_int_n;
  sched_evt_t        evt;
  logic              pend_q;
  logic [CW-1:0]     act_w_q;
  logic              bnd_w;

  // Reset asserts at once, releases after SYNC_STAGES clean edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_MSB-1:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_MSB];

  pwm_tail_sched #(.CW(CW)) u_sched (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .period_i (period_i),
    .width_i  (width_i),
    .pend_i   (pend_q),
    .evt_o    (evt)
  );

  pwm_tail_update #(.CW(CW)) u_upd (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .req_i     (upd_req_i),
    .consume_i (evt.load),
    .width_i   (width_i),
    .pend_o    (pend_q),
    .act_w_o   (act_w_q)
  );

  pwm_tail_out #(.CW(CW)) u_out (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .evt_i    (evt),
    .act_w_i  (act_w_q),
    .width_i  (width_i),
    .period_i (period_i),
    .pwm_o    (pwm_o),
    .pstart_o (period_start_o)
  );

  assign bnd_w = evt.bnd;

endmodule

// File: rtl/pwm_tail_gen_chk.sv
module pwm_tail_gen_chk #(
  parameter int unsigned CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] period_i,
  input logic          upd_req_i,
  input logic          pwm_o,
  input logic          period_start_o,
  input logic          pend,
  input logic [CW-1:0] act_w,
  input logic          bnd
);

  // R2: the boundary marker never lasts two cycles
  a_r2_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    period_start_o |=> !period_start_o);

  // R3: a partial-width period opens low
  a_r3_low_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    (period_start_o && (act_w < period_i)) |-> !pwm_o);

  // R3: once high, output holds until a boundary edge
  a_r3_high_until_end: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_o && !bnd) |=> pwm_o);

  // R4: zero active width never drives high
  a_r4_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
    (act_w == '0) |-> !pwm_o);

  // R5: saturated width opens high
  a_r5_full_high: assert property (@(posedge clk) disable iff (!rst_n)
    (period_start_o && (act_w >= period_i)) |-> pwm_o);

  // R6: active width moves only through a pending update
  a_r6_width_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !pend |=> $stable(act_w));

  // R7: a boundary consumes the pending flag
  a_r7_pend_consumed: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && bnd && !upd_req_i) |=> !pend);

  // R7: a request always leaves the flag set
  a_r7_pend_set: assert property (@(posedge clk) disable iff (!rst_n)
    upd_req_i |=> pend);

endmodule

bind pwm_tail_gen pwm_tail_gen_chk #(.CW(CW)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .period_i       (period_i),
  .upd_req_i      (upd_req_i),
  .pwm_o          (pwm_o),
  .period_start_o (period_start_o),
  .pend           (pend_q),
  .act_w          (act_w_q),
  .bnd            (bnd_w)
);

// File: tb/pwm_tail_gen_tb.sv
`timescale 1ns/1ps
module pwm_tail_gen_tb;

  localparam int PER      = 141;
  localparam int WATCHDOG = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] period_i = 16'(PER);
  logic [15:0] width_i = '0;
  logic        upd_req_i = 1'b0;
  logic        pwm_o;
  logic        period_start_o;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  pwm_tail_gen u_dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .period_i       (period_i),
    .width_i        (width_i),
    .upd_req_i      (upd_req_i),
    .pwm_o          (pwm_o),
    .period_start_o (period_start_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wait_start();
    int guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!period_start_o && guard < 70000);
  endtask

  // Called at the negedge sample where period_start_o is 1; returns at the next one
  task automatic sample_period(output int len, output int hi, output int first);
    len = 0; hi = 0; first = -1;
    do begin
      if (pwm_o) begin
        if (first < 0) first = len;
        hi++;
      end
      len++;
      @(negedge clk);
    end while (!period_start_o && len < 70000);
  endtask

  task automatic check_period(input int ew, input int ep, input string req);
    int len, hi, first, eh, ef;
    eh = (ew == 0) ? 0 : ((ew >= ep) ? ep : ew);
    ef = (eh == 0) ? -1 : ep - eh;
    sample_period(len, hi, first);
    check(len == ep, req, "period length", len, ep);
    check(hi == eh, req, "high cycles", hi, eh);
    check(first == ef, req, "first high index", first, ef);
  endtask

  task automatic request(input int w);
    @(negedge clk);
    width_i   = 16'(w);
    upd_req_i = 1'b1;
    @(negedge clk);
    upd_req_i = 1'b0;
  endtask

  task automatic t_reset();
    repeat (5) @(negedge clk);
    check(!pwm_o && !period_start_o, "R1", "outputs in reset",
          int'({pwm_o, period_start_o}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!pwm_o && !period_start_o, "R1", "outputs after release",
          int'({pwm_o, period_start_o}), 0);
  endtask

  task automatic t_idle();
    wait_start();
    check_period(0, PER, "R8");
    check_period(0, PER, "R2");
  endtask

  task automatic t_width_basic();
    request(50);
    wait_start();
    check_period(50, PER, "R3");
    check_period(50, PER, "R7");
  endtask

  task automatic t_ignore();
    @(negedge clk);
    width_i = 16'd99;
    wait_start();
    check_period(50, PER, "R6");
  endtask

  task automatic t_edges();
    request(1);   wait_start(); check_period(1, PER, "R3");
    request(140); wait_start(); check_period(140, PER, "R3");
    request(0);   wait_start(); check_period(0, PER, "R4");
    check_period(0, PER, "R4");
  endtask

  task automatic t_full();
    request(141); wait_start(); check_period(141, PER, "R5");
    check_period(141, PER, "R5");
    request(200); wait_start(); check_period(200, PER, "R5");
    request(30);  wait_start(); check_period(30, PER, "R7");
  endtask

  task automatic t_wrap();
    int len, hi, first, bad;
    bad = 0;
    request(70);
    wait_start();
    for (int i = 0; i < 480; i++) begin
      sample_period(len, hi, first);
      if (len != PER || hi != 70 || first != PER - 70) bad++;
    end
    check(bad == 0, "R9", "periods wrong across rollover", bad, 0);
  endtask

  task automatic t_period();
    @(negedge clk);
    period_i  = 16'd20;
    width_i   = 16'd5;
    upd_req_i = 1'b1;
    @(negedge clk);
    upd_req_i = 1'b0;
    wait_start();
    check_period(5, 20, "R2");
    check_period(5, 20, "R3");
  endtask

  initial begin
    t_reset();
    t_idle();
    t_width_basic();
    t_ignore();
    t_edges();
    t_full();
    t_wrap();
    t_period();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog run did not complete actual=%0d expected=0", WATCHDOG);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule